// File: doc/BRIEF.md
# Keyed Stream Scrambler/Descrambler

This block hides a bit-serial digitized voice stream by XOR-ing each data bit with one bit of a pseudo-random keystream. One datapath serves both directions. In transmit it scrambles the encoder output. In receive it descrambles the demodulated stream. A direction input only chooses which way the stream flows; both directions use the same keystream.

The keystream comes from a 23-bit maximal-length shift register. A key manager watches the code-select input and the direction input. When either one changes, it fetches the chosen key from an eight-slot key memory and seeds the register with it. The seed is in place before the next data bit is combined. A key of all zeros would stall the register, so the manager replaces it with a fixed nonzero seed. A separate write port fills the key memory. Data bits are processed only on cycles where the bit-clock enable is high, so the data rate is set entirely by that enable.

Top module: `kstream_scrambler`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `dout` and `dout_vld` are 0. Every key slot resets to all zeros.
- R2: `dout_vld` is high exactly one cycle after a cycle with `bit_en` high. In that cycle `dout` equals the `din` sampled with the enable XOR the current keystream bit. The keystream bit is bit 0 of the generator state.
- R3: The generator state is 23 bits wide and advances once for each `bit_en` cycle. The next state is `{s[0]^s[5], s[22:1]}`. The state is never all zeros.
- R4: A load seeds the generator with the key stored in the slot numbered by `code_sel`. A stored key of zero is replaced by the seed 23'h2A5A5A. The first cycle after reset performs a load.
- R5: When `code_sel` differs from its value in the previous cycle, the generator reloads. If `bit_en` is high in that same cycle, that bit already uses bit 0 of the new seed.
- R6: When `dir_rx` changes (0 = transmit/scramble, 1 = receive/descramble), the generator reloads in the same way as in R5.
- R7: Scrambling a bit sequence in transmit mode and then feeding the result back in receive mode with the same code select returns the original sequence.
- R8: A cycle with `key_wr_en` high stores `key_wr_data` in slot `key_wr_addr` on the next edge. The write does not reload the generator. The new key takes effect at the next load.
- R9: In cycles with `bit_en` low, `din` is ignored, `dout` holds its value and the generator state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one data bit per high cycle |
| dir_rx | input | 1 | Direction: 0 scramble (transmit), 1 descramble (receive) |
| code_sel | input | 3 | Key slot chosen for seeding |
| din | input | 1 | Serial data in |
| key_wr_en | input | 1 | Key memory write strobe |
| key_wr_addr | input | 3 | Key slot to write |
| key_wr_data | input | 23 | Key value to write |
| dout | output | 1 | Serial data out (scrambled or descrambled) |
| dout_vld | output | 1 | High for the cycle in which `dout` carries a new bit |

## Verification
The embedded assertions check the following on every cycle:
- the generator state is never zero;
- it holds when neither an enable nor a load occurs;
- it steps by the stated feedback when it advances;
- any change of code select or direction raises a reload with a nonzero seed;
- key writes land in the addressed slot;
- the valid flag and output hold follow the enable.

Only the bench's scenarios can show the rest:
- that the output stream matches the keystream of the right key;
- that the fallback seed replaces a zero key;
- that a write to the active slot waits for the next reload;
- that a scramble followed by a descramble returns the original data.

// File: rtl/kstream_pkg.sv
package kstream_pkg;

    // Generator and key memory geometry
    localparam int KEY_W    = 23;
    localparam int NUM_KEYS = 8;
    localparam int SEL_W    = $clog2(NUM_KEYS);
    // Feedback tap for x^23 + x^18 + 1, counted from the output end
    localparam int TAP_POS  = KEY_W - 18;

    localparam logic [KEY_W-1:0] FALLBACK_SEED = 23'h2A5A5A;

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    // Reload request passed from key manager to generator
    typedef struct packed {
        logic load;
        key_t seed;
    } reload_t;

    // Registered output bit
    typedef struct packed {
        logic valid;
        logic data;
    } obit_t;

    function automatic key_t lfsr_step(key_t s);
        return {s[0] ^ s[TAP_POS], s[KEY_W-1:1]};
    endfunction

    function automatic key_t seed_fix(key_t k);
        return (k == '0) ? FALLBACK_SEED : k;
    endfunction

endpackage

// File: rtl/kstream_keystore.sv
module kstream_keystore
    import kstream_pkg::*;
#(
    parameter int N_SLOTS = NUM_KEYS
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  sel_t wr_addr,
    input  key_t wr_data,
    input  sel_t rd_sel,
    output key_t rd_key
);

    key_t slots [N_SLOTS];
    logic [N_SLOTS-1:0] hit;

    // One write decode per slot
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_addr == sel_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SLOTS; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < N_SLOTS; i++) begin
                if (hit[i]) slots[i] <= wr_data;
            end
        end
    end

    assign rd_key = slots[rd_sel];

    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slots[$past(wr_addr)] == $past(wr_data))
        else $error("key write did not land");

    p_onehot_write_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit))
        else $error("more than one slot written");

endmodule

// File: rtl/kstream_keymgr.sv
module kstream_keymgr
    import kstream_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sel_t    code_sel,
    input  dir_e    dir,
    input  key_t    slot_key,
    output reload_t reload
);

    sel_t sel_q;
    dir_e dir_q;
    logic primed_q;
    logic sel_moved, dir_moved;

    assign sel_moved = (code_sel != sel_q);
    assign dir_moved = (dir != dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            dir_q    <= DIR_TX;
            primed_q <= 1'b0;
        end else begin
            sel_q    <= code_sel;
            dir_q    <= dir;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        reload.load = !primed_q || sel_moved || dir_moved;
        reload.seed = seed_fix(slot_key);
    end

    p_reload_on_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && code_sel != $past(code_sel)) |-> reload.load)
        else $error("code select change without reload");

    p_reload_on_dir_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && dir != $past(dir)) |-> reload.load)
        else $error("direction change without reload");

    p_seed_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        reload.load |-> reload.seed != '0)
        else $error("zero seed offered");

    p_first_load_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reload.load)
        else $error("no load after reset");

endmodule

// File: rtl/kstream_lfsr.sv
module kstream_lfsr
    import kstream_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reload_t reload,
    input  logic    adv,
    output logic    ks_bit
);

    key_t state;
    key_t eff;

    // A pending reload takes effect for a bit in the same cycle
    assign eff    = reload.load ? reload.seed : state;
    assign ks_bit = eff[0];

    always_ff @(posedge clk) begin
        if (rst)              state <= FALLBACK_SEED;
        else if (adv)         state <= lfsr_step(eff);
        else if (reload.load) state <= reload.seed;
    end

    p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
        state != '0)
        else $error("generator state is zero");

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(adv) && !$past(reload.load)) |-> $stable(state))
        else $error("generator moved while idle");

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && !$past(reload.load)) |->
            state == {$past(state[0]) ^ $past(state[TAP_POS]), $past(state[KEY_W-1:1])})
        else $error("generator step wrong");

endmodule

// File: rtl/kstream_scrambler.sv
module kstream_scrambler
    import kstream_pkg::*;
#(
    parameter int K_W   = KEY_W,
    parameter int S_W   = SEL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_en,
    input  logic           dir_rx,
    input  logic [S_W-1:0] code_sel,
    input  logic           din,
    input  logic           key_wr_en,
    input  logic [S_W-1:0] key_wr_addr,
    input  logic [K_W-1:0] key_wr_data,
    output logic           dout,
    output logic           dout_vld
);

    key_t    slot_key;
    reload_t reload;
    logic    ks_bit;
    obit_t   ob;
    dir_e    dir;

    assign dir = dir_e'(dir_rx);

    kstream_keystore #(.N_SLOTS(NUM_KEYS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (key_wr_en),
        .wr_addr (key_wr_addr),
        .wr_data (key_wr_data),
        .rd_sel  (code_sel),
        .rd_key  (slot_key)
    );

    kstream_keymgr u_mgr (
        .clk      (clk),
        .rst      (rst),
        .code_sel (code_sel),
        .dir      (dir),
        .slot_key (slot_key),
        .reload   (reload)
    );

    kstream_lfsr u_gen (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .adv    (bit_en),
        .ks_bit (ks_bit)
    );

    // Shared combine stage for both directions
    always_ff @(posedge clk) begin
        if (rst) begin
            ob <= '0;
        end else begin
            ob.valid <= bit_en;
            if (bit_en) ob.data <= din ^ ks_bit;
        end
    end

    assign dout     = ob.data;
    assign dout_vld = ob.valid;

    p_vld_follows_en_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dout_vld == $past(bit_en))
        else $error("valid not aligned to enable");

    p_dout_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bit_en)) |-> $stable(dout))
        else $error("output changed without enable");

endmodule

// File: tb/kstream_scrambler_tb_top.sv
module kstream_scrambler_tb_top;
    import kstream_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, bit_en, dir_rx, din, key_wr_en;
    sel_t code_sel, key_wr_addr;
    key_t key_wr_data;
    logic dout, dout_vld;

    kstream_scrambler dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .dir_rx(dir_rx),
        .code_sel(code_sel), .din(din), .key_wr_en(key_wr_en),
        .key_wr_addr(key_wr_addr), .key_wr_data(key_wr_data),
        .dout(dout), .dout_vld(dout_vld)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    key_t mkeys [8];
    key_t ms;
    sel_t m_sel;
    logic m_dir;
    logic got;

    // {sel[2:0], dir, 16-bit pattern}
    localparam logic [19:0] VEC [10] = '{
        {3'd1, 1'b0, 16'hA5C3}, {3'd2, 1'b0, 16'hFFFF}, {3'd2, 1'b1, 16'h0000},
        {3'd3, 1'b1, 16'h1234}, {3'd7, 1'b0, 16'hF0F0}, {3'd5, 1'b0, 16'h8001},
        {3'd6, 1'b1, 16'h5555}, {3'd0, 1'b1, 16'hC0DE}, {3'd4, 1'b0, 16'h7E81},
        {3'd1, 1'b1, 16'h3C3C}
    };

    function automatic key_t m_step(key_t s);
        return {s[0] ^ s[5], s[22:1]};
    endfunction

    function automatic key_t m_seed(key_t k);
        return (k == '0) ? 23'h2A5A5A : k;
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic set_ctrl(sel_t s, logic d);
        @(negedge clk);
        code_sel = s;
        dir_rx   = d;
        if (s != m_sel || d != m_dir) ms = m_seed(mkeys[s]);
        m_sel = s;
        m_dir = d;
    endtask

    task automatic send_bit(logic b, string rq, output logic o);
        logic e;
        @(negedge clk);
        din    = b;
        bit_en = 1'b1;
        e      = b ^ ms[0];
        ms     = m_step(ms);
        @(negedge clk);
        bit_en = 1'b0;
        chk(rq, dout, e);
        chk({rq, " valid"}, dout_vld, 1'b1);
        o = dout;
    endtask

    task automatic write_key(sel_t a, key_t k);
        @(negedge clk);
        key_wr_en   = 1'b1;
        key_wr_addr = a;
        key_wr_data = k;
        @(negedge clk);
        key_wr_en = 1'b0;
        mkeys[a]  = k;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic held;
        logic [15:0] orig, scr;
        rst = 1'b1; bit_en = 1'b0; dir_rx = 1'b0; din = 1'b0;
        key_wr_en = 1'b0; code_sel = '0; key_wr_addr = '0; key_wr_data = '0;
        m_sel = '0; m_dir = 1'b0;
        for (int i = 0; i < 8; i++) mkeys[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dout in reset", dout, 1'b0);
        chk("R1 vld in reset", dout_vld, 1'b0);
        rst = 1'b0;
        ms  = m_seed(mkeys[0]);
        @(negedge clk);
        chk("R1 dout after reset", dout, 1'b0);
        chk("R1 vld after reset", dout_vld, 1'b0);

        // R4: all-zero slot uses fallback seed; R2/R3 stream
        for (int j = 0; j < 8; j++) send_bit(j[0] ^ j[2], "R4 fallback", got);

        // R8: fill slots 1..6
        for (int i = 1; i < 7; i++) write_key(sel_t'(i), key_t'(23'h13579B ^ (i * 23'h04F1D3)));

        // R2/R3/R5/R6: vector table
        for (int v = 0; v < 10; v++) begin
            set_ctrl(VEC[v][19:17], VEC[v][16]);
            for (int j = 0; j < 16; j++) send_bit(VEC[v][j], "R2 table", got);
        end

        // R9: idle cycles with din toggling
        held = dout;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            din = ~din;
            chk("R9 dout hold", dout, held);
            chk("R9 vld low", dout_vld, 1'b0);
        end
        for (int j = 0; j < 4; j++) send_bit(j[0], "R9 resume", got);

        // R6: flip direction only
        set_ctrl(m_sel, ~m_dir);
        for (int j = 0; j < 8; j++) send_bit(1'b1, "R6 dir reload", got);

        // R5: select change in the same cycle as a bit
        @(negedge clk);
        code_sel = 3'd5;
        din      = 1'b0;
        bit_en   = 1'b1;
        ms       = m_seed(mkeys[5]);
        m_sel    = 3'd5;
        held     = ms[0];
        ms       = m_step(ms);
        @(negedge clk);
        bit_en = 1'b0;
        chk("R5 same-cycle reload", dout, held);
        for (int j = 0; j < 6; j++) send_bit(j[1], "R5 after reload", got);

        // R8: write to active slot does not reload
        set_ctrl(3'd2, 1'b0);
        for (int j = 0; j < 4; j++) send_bit(1'b0, "R8 before write", got);
        write_key(3'd2, 23'h0ABCDE);
        for (int j = 0; j < 6; j++) send_bit(1'b0, "R8 no reload on write", got);
        set_ctrl(3'd3, 1'b0);
        set_ctrl(3'd2, 1'b0);
        for (int j = 0; j < 8; j++) send_bit(j[0], "R8 new key used", got);

        // R4: zeroed slot reverts to fallback
        write_key(3'd6, '0);
        set_ctrl(3'd6, 1'b0);
        for (int j = 0; j < 6; j++) send_bit(1'b1, "R4 zero key", got);

        // R7: scramble then descramble
        orig = 16'hB6D1;
        set_ctrl(3'd4, 1'b1);
        set_ctrl(3'd4, 1'b0);
        for (int j = 0; j < 16; j++) begin
            send_bit(orig[j], "R7 scramble", got);
            scr[j] = got;
        end
        set_ctrl(3'd4, 1'b1);
        for (int j = 0; j < 16; j++) begin
            send_bit(scr[j], "R7 descramble", got);
            chk("R7 recovered", got, orig[j]);
        end

        summary();
        $finish;
    end

endmodule